// File: doc/BRIEF.md
# Chained-Descriptor Copy Engine

One DMA channel that works through a list of transfer descriptors held in memory. Software writes the address of the first descriptor and then sets the run bit. The engine reads the six-word descriptor and copies the bytes it describes, one beat at a time, through a simple word-wide memory master. It then follows the descriptor's link word to the next descriptor. A link equal to the end marker closes the list. The engine then raises a list-finished event and clears its own run bit.

Each descriptor has six 32-bit words, read at consecutive word addresses: a packed configuration word, the source address, the destination address, the byte count, a free parameter word, and the link. The configuration word has one 16-bit half for each side: the low half for the source and the high half for the destination. Each half selects that side's access width and whether its address walks forward or stays fixed. A register port can pause and resume the channel or stop it outright. The same port reads back the live source and destination pointers, the bytes still to move, the current descriptor address, and the configuration and parameter words.

Top module: `dcw_walker`

## Requirements
- R1: After reset every register reads 0, mem_req is low and neither event output is high.
- R2: Writing bit 0 = 1 to register index 0 (run) while idle starts fetching the six descriptor words in order at the address held in register index 2 (start), one word address apart. Register index 3 then reads the current descriptor address. Writing 1 while already running has no effect.
- R3: Each beat reads the source pointer and then writes the word it read to the destination pointer. A memory access completes in a cycle where mem_req and mem_ack are both high, and read data is taken in that same cycle. After each beat the byte count (register index 6) drops by the source width in bytes and stops at zero.
- R4: A side's width code sits in bits 10:9 of its half (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8) and is driven on mem_size during that side's accesses. Descriptor fetches use code 2. The side's address mode sits in bits 6:5: code 1 holds the address fixed, and any other code advances it by the width in bytes after each beat.
- R5: evt_pkg_end pulses for exactly one cycle when a descriptor finishes. A descriptor with a zero byte count makes no data accesses, still pulses evt_pkg_end, and moves on.
- R6: When the finished descriptor's link is 0xFFFFF800, evt_queue_end pulses in the same cycle as evt_pkg_end and the run bit reads 0 afterwards. Any other link becomes the current descriptor address and fetching continues there.
- R7: While the pause bit (register index 1, bit 0) is 1, mem_req stays low and the source pointer, destination pointer and byte count hold their values. Clearing the bit resumes from the same point.
- R8: Writing bit 0 = 0 to the run register stops the channel. From the next cycle mem_req is low, the run bit reads 0, and no evt_queue_end follows.
- R9: Register index 7 reads the whole configuration word of the current descriptor and index 8 reads its parameter word. Bits 4:0 of each half (request type) and bits 8:7 are stored but have no effect on the transfer. Unlisted indices read 0.
- R10: The low half of the configuration word governs the source side and the high half the destination side. The two widths and modes can differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access completes in this cycle when high together with mem_req |
| mem_rdata | input | DW | Read data, valid in the acknowledge cycle |
| evt_pkg_end | output | 1 | One-cycle pulse when a descriptor finishes |
| evt_queue_end | output | 1 | One-cycle pulse when the last descriptor of the list finishes |

## Verification
The alignment assertion assumes that the start address and every non-final link are word aligned. All descriptors in the stimulus are placed on word boundaries. The hold assertions assume that memory acknowledges only requests that are present, and the bench model gates its acknowledge with mem_req. Its stall mode only withholds acknowledges on alternate cycles and never invents one. The ordering assertions assume that software does not write the run register in the same cycle the list finishes, so the bench issues run writes only while the engine is idle or mid-transfer.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
   // link value that closes a descriptor list
   localparam logic [31:0] DCW_END_LINK = 32'hFFFF_F800;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_READ,
      S_WRITE,
      S_CLOSE
   } dcw_state_e;

   // word positions inside a descriptor (fetch order)
   localparam logic [2:0] W_CFG  = 3'd0;
   localparam logic [2:0] W_SRC  = 3'd1;
   localparam logic [2:0] W_DST  = 3'd2;
   localparam logic [2:0] W_CNT  = 3'd3;
   localparam logic [2:0] W_PARA = 3'd4;
   localparam logic [2:0] W_LINK = 3'd5;

   // field positions inside one 16-bit half of the config word
   localparam int HALF_W = 16;
   localparam int WC_LO  = 9;
   localparam int AM_LO  = 5;
   localparam logic [1:0] AM_FIXED = 2'd1;

   // register word indices
   localparam logic [3:0] RA_RUN   = 4'd0;
   localparam logic [3:0] RA_PAUSE = 4'd1;
   localparam logic [3:0] RA_START = 4'd2;
   localparam logic [3:0] RA_DESC  = 4'd3;
   localparam logic [3:0] RA_SRC   = 4'd4;
   localparam logic [3:0] RA_DST   = 4'd5;
   localparam logic [3:0] RA_LEFT  = 4'd6;
   localparam logic [3:0] RA_CFG   = 4'd7;
   localparam logic [3:0] RA_PARAM = 4'd8;
endpackage

// File: rtl/dcw_addr_ptr.sv
module dcw_addr_ptr
   import dcw_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [AW-1:0] ld_val,
   input  logic          step,
   input  logic [1:0]    wcode,
   input  logic [1:0]    amode,
   output logic [AW-1:0] ptr
);
   logic [AW-1:0] inc;
   assign inc = AW'(1) << wcode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ptr <= '0;
      else if (ld)                       ptr <= ld_val;
      else if (step && amode != AM_FIXED) ptr <= ptr + inc;
   end

   // R4: a fixed side never moves on a beat
   a_r4_fixed_side_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld && amode == AM_FIXED) |=> (ptr == $past(ptr)));
endmodule

// File: rtl/dcw_count.sv
module dcw_count #(
   parameter int CW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   input  logic          dec,
   input  logic [1:0]    wcode,
   output logic [CW-1:0] left,
   output logic          is_zero,
   output logic          last_beat
);
   logic [CW-1:0] beat;
   assign beat      = CW'(1) << wcode;
   assign is_zero   = (left == '0);
   assign last_beat = (left <= beat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      left <= '0;
      else if (ld)     left <= ld_val;
      else if (dec)    left <= (left > beat) ? left - beat : '0;
   end

   // R3: between loads the count only goes down
   a_r3_left_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> (left <= $past(left)));
endmodule

// File: rtl/dcw_desc_store.sv
module dcw_desc_store
   import dcw_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cap,
   input  logic [2:0]  idx,
   input  logic [31:0] word,
   output logic [31:0] cfg,
   output logic [31:0] para,
   output logic [31:0] link
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg  <= '0;
         para <= '0;
         link <= '0;
      end else if (cap) begin
         case (idx)
            W_CFG:   cfg  <= word;
            W_PARA:  para <= word;
            W_LINK:  link <= word;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dcw_seq.sv
module dcw_seq
   import dcw_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          halt,
   input  logic          hold,
   input  logic          mem_ack,
   input  logic          cnt_zero,
   input  logic          cnt_last,
   input  logic [31:0]   link,
   input  logic [AW-1:0] start_addr,
   output dcw_state_e    state,
   output logic [2:0]    fidx,
   output logic [AW-1:0] desc_addr,
   output logic          access,
   output logic          cap,
   output logic          rd_take,
   output logic          wr_done,
   output logic          pkg_evt,
   output logic          queue_evt
);
   logic fire;
   logic at_end;

   assign access    = (state == S_FETCH) || (state == S_READ) || (state == S_WRITE);
   assign fire      = access && !hold && mem_ack;
   assign cap       = (state == S_FETCH) && fire;
   assign rd_take   = (state == S_READ)  && fire;
   assign wr_done   = (state == S_WRITE) && fire;
   assign at_end    = (link == DCW_END_LINK);
   assign pkg_evt   = (state == S_CLOSE);
   assign queue_evt = pkg_evt && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         fidx      <= '0;
         desc_addr <= '0;
      end else if (halt) begin
         state <= S_IDLE;
         fidx  <= '0;
      end else begin
         case (state)
            S_IDLE: if (go) begin
               state     <= S_FETCH;
               fidx      <= '0;
               desc_addr <= start_addr;
            end
            S_FETCH: if (fire) begin
               if (fidx == W_LINK) begin
                  fidx  <= '0;
                  state <= cnt_zero ? S_CLOSE : S_READ;
               end else begin
                  fidx <= fidx + 3'd1;
               end
            end
            S_READ:  if (fire) state <= S_WRITE;
            S_WRITE: if (fire) state <= cnt_last ? S_CLOSE : S_READ;
            S_CLOSE: begin
               if (at_end) begin
                  state <= S_IDLE;
               end else begin
                  state     <= S_FETCH;
                  fidx      <= '0;
                  desc_addr <= link[AW-1:0];
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R2: a start from idle begins at word 0 of the start address
   a_r2_start_at_first_word: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && go && !halt) |=>
      (state == S_FETCH && fidx == 3'd0 && desc_addr == $past(start_addr)));

   // R5: a descriptor close lasts a single cycle
   a_r5_close_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      pkg_evt |=> !pkg_evt);
endmodule

// File: rtl/dcw_walker.sv
module dcw_walker
   import dcw_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [3:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_size,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          evt_pkg_end,
   output logic          evt_queue_end
);
   localparam int NSIDE = 2;

   if (DW != 32) begin : g_bad_dw
      $error("dcw_walker: descriptor layout needs DW == 32");
   end
   if (AW < 12 || AW > 32) begin : g_bad_aw
      $error("dcw_walker: AW must lie in 12..32");
   end
   if (CW < 4 || CW > 32) begin : g_bad_cw
      $error("dcw_walker: CW must lie in 4..32");
   end

   logic          run_q, pause_q;
   logic [AW-1:0] start_q;
   logic          run_wr, go, halt;
   dcw_state_e    state;
   logic [2:0]    fidx;
   logic [AW-1:0] desc_addr;
   logic          access, cap, rd_take, wr_done, pkg_evt, queue_evt;
   logic [31:0]   cfg_q, para_q, link_q;
   logic [CW-1:0] left;
   logic          cnt_zero, cnt_last;
   logic [DW-1:0] data_q;
   logic [AW-1:0] ptr_a [NSIDE];

   // register writes
   assign run_wr = reg_we && (reg_addr == RA_RUN);
   assign go     = run_wr && reg_wdata[0];
   assign halt   = run_wr && !reg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         pause_q <= 1'b0;
         start_q <= '0;
      end else begin
         if (run_wr)         run_q <= reg_wdata[0];
         else if (queue_evt) run_q <= 1'b0;
         if (reg_we && reg_addr == RA_PAUSE) pause_q <= reg_wdata[0];
         if (reg_we && reg_addr == RA_START) start_q <= reg_wdata[AW-1:0];
      end
   end

   dcw_seq #(.AW(AW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .halt       (halt),
      .hold       (pause_q),
      .mem_ack    (mem_ack),
      .cnt_zero   (cnt_zero),
      .cnt_last   (cnt_last),
      .link       (link_q),
      .start_addr (start_q),
      .state      (state),
      .fidx       (fidx),
      .desc_addr  (desc_addr),
      .access     (access),
      .cap        (cap),
      .rd_take    (rd_take),
      .wr_done    (wr_done),
      .pkg_evt    (pkg_evt),
      .queue_evt  (queue_evt)
   );

   dcw_desc_store u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (cap),
      .idx   (fidx),
      .word  (mem_rdata),
      .cfg   (cfg_q),
      .para  (para_q),
      .link  (link_q)
   );

   // one pointer per side; side 0 = source (low half), side 1 = destination (high half)
   for (genvar g = 0; g < NSIDE; g++) begin : g_side
      dcw_addr_ptr #(.AW(AW)) u_ptr (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld     (cap && fidx == ((g == 0) ? W_SRC : W_DST)),
         .ld_val (mem_rdata[AW-1:0]),
         .step   (wr_done),
         .wcode  (cfg_q[HALF_W*g + WC_LO +: 2]),
         .amode  (cfg_q[HALF_W*g + AM_LO +: 2]),
         .ptr    (ptr_a[g])
      );
   end

   dcw_count #(.CW(CW)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (cap && fidx == W_CNT),
      .ld_val    (mem_rdata[CW-1:0]),
      .dec       (wr_done),
      .wcode     (cfg_q[WC_LO +: 2]),
      .left      (left),
      .is_zero   (cnt_zero),
      .last_beat (cnt_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (rd_take) data_q <= mem_rdata;
   end

   // memory master
   assign mem_req   = access && !pause_q;
   assign mem_we    = (state == S_WRITE);
   assign mem_wdata = data_q;

   always_comb begin
      mem_addr = '0;
      mem_size = 2'd2;
      case (state)
         S_FETCH: mem_addr = desc_addr + AW'({fidx, 2'b00});
         S_READ: begin
            mem_addr = ptr_a[0];
            mem_size = cfg_q[WC_LO +: 2];
         end
         S_WRITE: begin
            mem_addr = ptr_a[1];
            mem_size = cfg_q[HALF_W + WC_LO +: 2];
         end
         default: ;
      endcase
   end

   assign evt_pkg_end   = pkg_evt;
   assign evt_queue_end = queue_evt;

   // register read-back
   always_comb begin
      case (reg_addr)
         RA_RUN:   reg_rdata = {31'd0, run_q};
         RA_PAUSE: reg_rdata = {31'd0, pause_q};
         RA_START: reg_rdata = 32'(start_q);
         RA_DESC:  reg_rdata = 32'(desc_addr);
         RA_SRC:   reg_rdata = 32'(ptr_a[0]);
         RA_DST:   reg_rdata = 32'(ptr_a[1]);
         RA_LEFT:  reg_rdata = 32'(left);
         RA_CFG:   reg_rdata = cfg_q;
         RA_PARAM: reg_rdata = para_q;
         default:  reg_rdata = '0;
      endcase
   end

   // R7: pause freezes pointers and count
   a_r7_pause_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      pause_q |=> ($stable(ptr_a[0]) && $stable(ptr_a[1]) && $stable(left)));

   // R6: list end clears the run bit unless software writes it in that cycle
   a_r6_end_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_queue_end && !run_wr) |=> !run_q);

   // R6: list end coincides with a descriptor end
   a_r6_queue_with_pkg: assert property (@(posedge clk) disable iff (!rst_n)
      evt_queue_end |-> evt_pkg_end);

   // R8: a stop write drops the request on the next cycle
   a_r8_halt_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !mem_req);

   // R2: descriptor fetches are word aligned (aligned start and links assumed)
   a_r2_fetch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && state == S_FETCH) |-> (mem_addr[1:0] == 2'b00));
endmodule

// File: tb/dcw_walker_bench.sv
`timescale 1ns/1ps
module dcw_walker_bench;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int CW = 24;
   localparam logic [31:0] ENDL = 32'hFFFF_F800;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [1:0]    mem_size;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic          evt_pkg_end, evt_queue_end;

   always #2.5 clk = ~clk;

   dcw_walker #(.AW(AW), .DW(DW), .CW(CW)) u_dcw_walker (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .mem_req, .mem_we, .mem_addr, .mem_size, .mem_wdata, .mem_ack, .mem_rdata,
      .evt_pkg_end, .evt_queue_end
   );

   // memory model, 2 KB
   logic [31:0] mem [0:511];
   logic ack_on = 1'b1;
   logic stall_mode = 1'b0;
   int wr_n = 0, pkg_n = 0, q_n = 0, lone_q_n = 0;
   logic [31:0] last_wr_addr = '0;
   logic [1:0]  last_rd_size = '0;

   assign mem_ack   = mem_req && ack_on;
   assign mem_rdata = mem[mem_addr[10:2]];

   always @(posedge clk) begin
      if (mem_req && mem_ack && mem_we) begin
         mem[mem_addr[10:2]] <= mem_wdata;
         wr_n <= wr_n + 1;
         last_wr_addr <= mem_addr;
      end
      if (mem_req && mem_ack && !mem_we && mem_addr >= 32'h200)
         last_rd_size <= mem_size;
      if (rst_n && evt_pkg_end) pkg_n <= pkg_n + 1;
      if (rst_n && evt_queue_end) q_n <= q_n + 1;
      if (rst_n && evt_queue_end && !evt_pkg_end) lone_q_n <= lone_q_n + 1;
   end

   always @(negedge clk) ack_on <= stall_mode ? ~ack_on : 1'b1;

   int total = 0, passed = 0;
   bit finished = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act === exp) passed++;
      else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
   endtask

   task automatic wr_reg(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(logic [3:0] a, output logic [31:0] v);
      reg_addr = a;
      #0.1;
      v = reg_rdata;
   endtask

   task automatic wait_q(int target);
      int n = 0;
      while (q_n < target && n < 3000) begin
         @(negedge clk);
         n++;
      end
   endtask

   function automatic logic [31:0] half(int w, int m, int rt);
      return 32'((w << 9) | (m << 5) | rt);
   endfunction

   function automatic logic [31:0] mk_cfg(int sw, int sm, int dw, int dm);
      return (half(dw, dm, 5'h03) << 16) | half(sw, sm, 5'h1F);
   endfunction

   task automatic put_desc(int base, logic [31:0] cfg, logic [31:0] src, logic [31:0] dst,
                           logic [31:0] cnt, logic [31:0] para, logic [31:0] link);
      mem[base/4 + 0] = cfg;
      mem[base/4 + 1] = src;
      mem[base/4 + 2] = dst;
      mem[base/4 + 3] = cnt;
      mem[base/4 + 4] = para;
      mem[base/4 + 5] = link;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      for (int a = 0; a < 9; a++) begin
         rd_reg(4'(a), v);
         chk($sformatf("R1 reg %0d after reset", a), v, 32'h0);
      end
      chk("R1 mem_req after reset", {31'd0, mem_req}, 32'h0);
      chk("R1 events after reset", {30'd0, evt_pkg_end, evt_queue_end}, 32'h0);
   endtask

   task automatic t_single;
      logic [31:0] v;
      int p0 = pkg_n, q0 = q_n;
      logic [31:0] cfg = mk_cfg(2, 0, 2, 0);
      put_desc('h000, cfg, 32'h200, 32'h300, 12, 32'h0000_00A5, ENDL);
      wr_reg(4'd2, 32'h0);
      wr_reg(4'd0, 32'h1);
      chk("R2 first fetch address", mem_addr, 32'h0);
      chk("R2 first fetch is a read", {31'd0, mem_req & ~mem_we}, 32'h1);
      rd_reg(4'd3, v); chk("R2 current descriptor", v, 32'h0);
      wait_q(q0 + 1);
      for (int i = 0; i < 3; i++)
         chk($sformatf("R3 copied word %0d", i), mem['h300/4 + i], 32'hC0DE_0000 + 32'(i));
      chk("R5 one package event", 32'(pkg_n - p0), 32'd1);
      chk("R6 one queue event", 32'(q_n - q0), 32'd1);
      rd_reg(4'd0, v); chk("R6 run bit cleared", v, 32'h0);
      rd_reg(4'd6, v); chk("R3 bytes left zero", v, 32'h0);
      rd_reg(4'd4, v); chk("R4 source advanced by 4 per beat", v, 32'h20C);
      rd_reg(4'd5, v); chk("R4 destination advanced by 4 per beat", v, 32'h30C);
      rd_reg(4'd7, v); chk("R9 config read-back", v, cfg);
      rd_reg(4'd8, v); chk("R9 parameter read-back", v, 32'hA5);
      rd_reg(4'd12, v); chk("R9 unlisted index reads zero", v, 32'h0);
   endtask

   task automatic t_chain_stall;
      logic [31:0] v;
      int p0 = pkg_n, q0 = q_n;
      put_desc('h040, mk_cfg(2, 0, 2, 0), 32'h220, 32'h320, 8, 0, 32'h080);
      put_desc('h080, mk_cfg(2, 0, 2, 0), 32'h228, 32'h340, 4, 0, ENDL);
      stall_mode = 1'b1;
      wr_reg(4'd2, 32'h040);
      wr_reg(4'd0, 32'h1);
      wait_q(q0 + 1);
      stall_mode = 1'b0;
      chk("R6 chain word 0", mem['h320/4], mem['h220/4]);
      chk("R6 chain word 1", mem['h324/4], mem['h224/4]);
      chk("R6 second descriptor word", mem['h340/4], mem['h228/4]);
      chk("R5 two package events", 32'(pkg_n - p0), 32'd2);
      chk("R6 single queue event", 32'(q_n - q0), 32'd1);
      rd_reg(4'd3, v); chk("R6 link followed", v, 32'h080);
      chk("R6 queue never alone", 32'(lone_q_n), 32'd0);
   endtask

   task automatic t_zero_count;
      int p0 = pkg_n, q0 = q_n, w0 = wr_n;
      put_desc('h0C0, mk_cfg(2, 0, 2, 0), 32'h230, 32'h360, 0, 0, 32'h100);
      put_desc('h100, mk_cfg(2, 0, 2, 0), 32'h230, 32'h368, 4, 0, ENDL);
      wr_reg(4'd2, 32'h0C0);
      wr_reg(4'd0, 32'h1);
      wait_q(q0 + 1);
      chk("R5 zero-count makes no writes", 32'(wr_n - w0), 32'd1);
      chk("R5 zero-count still pulses", 32'(pkg_n - p0), 32'd2);
      chk("R5 untouched destination", mem['h360/4], 32'hDEAD_0000 + 32'h360/4);
      chk("R5 following descriptor copied", mem['h368/4], mem['h230/4]);
   endtask

   task automatic t_fixed_dst;
      logic [31:0] v;
      int q0 = q_n, w0 = wr_n;
      mem['h240/4] = 32'h1111_1111;
      mem['h244/4] = 32'h2222_2222;
      put_desc('h140, mk_cfg(2, 0, 2, 1), 32'h240, 32'h380, 8, 0, ENDL);
      wr_reg(4'd2, 32'h140);
      wr_reg(4'd0, 32'h1);
      wait_q(q0 + 1);
      chk("R4 fixed side got last word", mem['h380/4], 32'h2222_2222);
      chk("R4 next word untouched", mem['h384/4], 32'hDEAD_0000 + 32'h384/4);
      chk("R4 two writes", 32'(wr_n - w0), 32'd2);
      chk("R4 last write address", last_wr_addr, 32'h380);
      rd_reg(4'd5, v); chk("R10 destination fixed", v, 32'h380);
      rd_reg(4'd4, v); chk("R10 source still advanced", v, 32'h248);
   endtask

   task automatic t_half_width;
      logic [31:0] v;
      int q0 = q_n, w0 = wr_n;
      put_desc('h180, mk_cfg(1, 0, 2, 0), 32'h250, 32'h3A0, 5, 0, ENDL);
      wr_reg(4'd2, 32'h180);
      wr_reg(4'd0, 32'h1);
      wait_q(q0 + 1);
      chk("R3 saturating count gives three beats", 32'(wr_n - w0), 32'd3);
      rd_reg(4'd4, v); chk("R10 source steps by 2", v, 32'h256);
      rd_reg(4'd5, v); chk("R10 destination steps by 4", v, 32'h3AC);
      rd_reg(4'd6, v); chk("R3 count stops at zero", v, 32'h0);
      chk("R4 source size code on bus", {30'd0, last_rd_size}, 32'd1);
      chk("R3 third beat data", mem['h3A8/4], mem['h254/4]);
   endtask

   task automatic t_pause;
      logic [31:0] s0, l0, v;
      int q0 = q_n, w0 = wr_n;
      int req_seen = 0;
      put_desc('h1C0, mk_cfg(2, 0, 2, 0), 32'h260, 32'h3C0, 40, 0, ENDL);
      wr_reg(4'd2, 32'h1C0);
      wr_reg(4'd0, 32'h1);
      repeat (9) @(negedge clk);
      wr_reg(4'd1, 32'h1);
      rd_reg(4'd4, s0);
      rd_reg(4'd6, l0);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (mem_req) req_seen++;
      end
      chk("R7 no request while paused", 32'(req_seen), 32'd0);
      rd_reg(4'd4, v); chk("R7 source held", v, s0);
      rd_reg(4'd6, v); chk("R7 count held", v, l0);
      rd_reg(4'd1, v); chk("R7 pause bit reads 1", v, 32'h1);
      wr_reg(4'd1, 32'h0);
      wait_q(q0 + 1);
      chk("R7 resumed transfer writes all beats", 32'(wr_n - w0), 32'd10);
      for (int i = 0; i < 10; i++)
         chk($sformatf("R7 word %0d after resume", i), mem['h3C0/4 + i], mem['h260/4 + i]);
   endtask

   task automatic t_halt;
      logic [31:0] v;
      int q0 = q_n, w0;
      put_desc('h1E0, mk_cfg(2, 0, 2, 0), 32'h260, 32'h400, 40, 0, ENDL);
      wr_reg(4'd2, 32'h1E0);
      wr_reg(4'd0, 32'h1);
      repeat (10) @(negedge clk);
      wr_reg(4'd0, 32'h0);
      chk("R8 request dropped", {31'd0, mem_req}, 32'h0);
      rd_reg(4'd0, v); chk("R8 run bit reads 0", v, 32'h0);
      rd_reg(4'd6, v); chk("R8 stopped mid-transfer", {31'd0, v != 0}, 32'h1);
      w0 = wr_n;
      repeat (20) @(negedge clk);
      chk("R8 no further writes", 32'(wr_n - w0), 32'd0);
      chk("R8 no queue event", 32'(q_n - q0), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
      for (int i = 0; i < 64; i++)  mem['h200/4 + i] = 32'hC0DE_0000 + 32'(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_single;
      t_chain_stall;
      t_zero_count;
      t_fixed_dst;
      t_half_width;
      t_pause;
      t_halt;
      finished = 1;
      $display("%0d/%0d checks passed", passed, total);
      $finish;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000 && !finished) begin
         total++;
         $display("FAIL watchdog: run did not end, actual=%0d cycles expected<100000", cyc);
         $display("%0d/%0d checks passed", passed, total);
         $finish;
      end
   end
endmodule